// File: doc/BRIEF.md
# CAN controller host register and interrupt unit

This block is the byte-wide host-facing register file of a CAN controller running its extended register map. A host reads and writes single bytes by offset. The block keeps the mode, interrupt-enable and clock-divider registers. It builds the status and interrupt bytes from its own flags and from events reported by the receive buffer and the frame sender. It drives one level interrupt line.

A 13-byte window at offsets 16 to 28 changes meaning with the reset-mode bit. While the controller is held in reset, the first eight bytes of the window are the acceptance code and mask bytes, and the filter logic sees them at all times. In operating mode, host writes fill the transmit buffer and host reads return bytes from the head of the receive FIFO. Commands are turned into one-cycle pulses toward the frame sender, the receive buffer and the filters. Leaving reset mode produces one pulse that tells the filters to load the code and mask bytes and tells the receive buffer to clear its counts.

Top module: `canctl_regs`

## Requirements
- R1: After reset the mode byte reads 0x01, the status byte reads 0x3C (with `rx_pending` low), the interrupt byte and interrupt-enable byte read 0x00, the clock-divider byte at offset 31 reads 0x00, and `irq` is low.
- R2: Bit 7 of the clock-divider byte drives `ext_map_en`. While it is 0, offset 31 is the only accessible register: reads of any other offset return 0xFF and writes to them have no effect.
- R3: A write to offset 0 stores only bits [4:0]. Reading offset 0 returns those bits with bits [7:5] zero. Bit 0 is the reset-mode bit.
- R4: A mode write that changes bit 0 from 1 to 0 makes `op_enter` high for exactly the one cycle after the write. A mode write that leaves bit 0 at 1 or at 0 gives no pulse.
- R5: In reset mode, window offsets 16 to 23 write and read the acceptance bytes 0 to 7. `acc_cfg` carries acceptance byte k at bits [8k+7:8k]. Offsets 24 to 28 read as 0x00.
- R6: In operating mode, a window write at offset 16+k stores transmit byte k, which `tx_frame` carries at bits [8k+7:8k]. It leaves the acceptance bytes unchanged. A window read at offset 16+k sets `rx_win_idx` to k and returns `rx_win_data`.
- R7: A write to offset 16, in either mode, sets status bit 5 (transmit status).
- R8: A command byte (offset 1) with bit 0 set pulses `tx_req` for one cycle after the write and clears status bits 2 and 3. A `tx_done` pulse sets status bits 2 and 3, clears status bit 5 and sets interrupt bit 1.
- R9: Command bit 2 pulses `rx_release` for one cycle. Command bit 3 pulses `ovr_clear`, clears status bit 1 and clears interrupt bit 3. An `rx_overrun` pulse sets status bit 1 and interrupt bit 3, and it wins over a clear in the same cycle.
- R10: Offset 1 reads 0x00. Offsets 5 to 15 read 0x00. Offsets 29 and 30 read 0xFF. Writes to offsets 2 (status) and 3 (interrupt) are ignored.
- R11: Status bit 0 follows `rx_pending`. An `rx_stored` pulse sets interrupt bit 0, which stays set only while `rx_pending` is high. A read of offset 3 returns the interrupt byte and then clears it, except that bit 0 is set again at once while `rx_pending` is high.
- R12: Offset 4 is the interrupt-enable byte. `irq` is high exactly when some interrupt bit is set and its enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (read side effects at the clock edge) |
| host_addr | input | 5 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from the offset |
| irq | output | 1 | Level interrupt |
| ext_map_en | output | 1 | Extended register map selected |
| tx_req | output | 1 | One-cycle transmit request |
| tx_frame | output | 104 | Transmit buffer bytes |
| tx_done | input | 1 | Frame sender finished a frame |
| acc_cfg | output | 64 | Acceptance code and mask bytes |
| op_enter | output | 1 | Pulse on leaving reset mode: load filters, clear receive counts |
| rx_release | output | 1 | Release pulse to the receive buffer |
| ovr_clear | output | 1 | Overrun-clear pulse to the receive buffer |
| rx_pending | input | 1 | Receive buffer holds at least one message |
| rx_stored | input | 1 | A message was just stored |
| rx_overrun | input | 1 | A message was lost to overrun |
| rx_win_idx | output | 4 | Byte index within the receive window |
| rx_win_data | input | 8 | Receive buffer byte at `rx_win_idx` |

## Verification
The bench builds the block with its default values: a 13-byte window and 8 acceptance bytes. With these values, offsets 24 to 28 read as zero in reset mode, and the last transmit byte at offset 28 can be written and checked. The bench drives the receive-buffer and sender inputs by hand, one pulse at a time. This brings a set and a clear of the overrun flag in the same cycle within reach, as well as interrupt reads while messages are still pending.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

    localparam int unsigned CR_AW = 5;

    localparam logic [CR_AW-1:0] OFS_MODE = 5'd0;
    localparam logic [CR_AW-1:0] OFS_CMD  = 5'd1;
    localparam logic [CR_AW-1:0] OFS_STAT = 5'd2;
    localparam logic [CR_AW-1:0] OFS_INT  = 5'd3;
    localparam logic [CR_AW-1:0] OFS_IER  = 5'd4;
    localparam logic [CR_AW-1:0] OFS_WIN  = 5'd16;
    localparam logic [CR_AW-1:0] OFS_CDR  = 5'd31;

    // command byte bit positions
    localparam int unsigned CMD_TX  = 0;
    localparam int unsigned CMD_REL = 2;
    localparam int unsigned CMD_OVR = 3;

    // registered control state
    typedef struct packed {
        logic [4:0] mode;
        logic [7:0] ier;
        logic [7:0] cdr;
        logic       ovr;         // status bit 1
        logic       txbuf_free;  // status bit 2
        logic       tx_cplt;     // status bit 3
        logic       rx_stat;     // status bit 4
        logic       tx_stat;     // status bit 5
        logic       int_rx;      // interrupt bit 0
        logic       int_tx;      // interrupt bit 1
        logic       int_ovr;     // interrupt bit 3
        logic       tx_req;
        logic       rx_rel;
        logic       ovr_clr;
        logic       op_enter;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        mode: 5'h01, ier: 8'h00, cdr: 8'h00,
        ovr: 1'b0, txbuf_free: 1'b1, tx_cplt: 1'b1, rx_stat: 1'b1, tx_stat: 1'b1,
        int_rx: 1'b0, int_tx: 1'b0, int_ovr: 1'b0,
        tx_req: 1'b0, rx_rel: 1'b0, ovr_clr: 1'b0, op_enter: 1'b0
    };

    // access strobes from the decoder
    typedef struct packed {
        logic wr_mode;
        logic wr_cmd;
        logic wr_ier;
        logic wr_cdr;
        logic wr_win;
        logic rd_int;
    } strobe_t;

endpackage

// File: rtl/canctl_decode.sv
module canctl_decode
    import canctl_pkg::*;
#(
    parameter int WIN_BYTES = 13,
    localparam int IDX_W = $clog2(WIN_BYTES)
) (
    input  logic             wr,
    input  logic             rd,
    input  logic [CR_AW-1:0] addr,
    input  logic             ext,
    output strobe_t          stb,
    output logic             win_hit,
    output logic [IDX_W-1:0] win_idx
);
    logic [CR_AW-1:0] rel;

    always_comb begin
        rel     = addr - OFS_WIN;
        win_hit = (addr >= OFS_WIN) && (rel < CR_AW'(WIN_BYTES));
        win_idx = rel[IDX_W-1:0];

        // offset 31 stays writable whatever the map selection
        stb.wr_cdr  = wr && (addr == OFS_CDR);
        stb.wr_mode = wr && ext && (addr == OFS_MODE);
        stb.wr_cmd  = wr && ext && (addr == OFS_CMD);
        stb.wr_ier  = wr && ext && (addr == OFS_IER);
        stb.wr_win  = wr && ext && win_hit;
        stb.rd_int  = rd && ext && (addr == OFS_INT);
    end
endmodule

// File: rtl/canctl_rdmux.sv
module canctl_rdmux
    import canctl_pkg::*;
#(
    parameter int WIN_BYTES = 13,
    parameter int ACC_BYTES = 8,
    localparam int IDX_W = $clog2(WIN_BYTES)
) (
    input  logic [CR_AW-1:0]            addr,
    input  logic                        ext,
    input  logic [4:0]                  mode,
    input  logic [7:0]                  status,
    input  logic [7:0]                  intr,
    input  logic [7:0]                  ier,
    input  logic [7:0]                  cdr,
    input  logic [ACC_BYTES-1:0][7:0]   acc,
    input  logic                        win_hit,
    input  logic [IDX_W-1:0]            win_idx,
    input  logic [7:0]                  rx_byte,
    output logic [7:0]                  rdata
);
    logic [7:0] acc_sel;

    always_comb begin
        acc_sel = 8'h00;
        for (int k = 0; k < ACC_BYTES; k++) begin
            if (win_idx == IDX_W'(k)) acc_sel = acc[k];
        end
    end

    always_comb begin
        rdata = 8'hFF;
        if (addr == OFS_CDR) begin
            rdata = cdr;
        end else if (ext) begin
            if (addr == OFS_MODE)       rdata = {3'b000, mode};
            else if (addr == OFS_CMD)   rdata = 8'h00;
            else if (addr == OFS_STAT)  rdata = status;
            else if (addr == OFS_INT)   rdata = intr;
            else if (addr == OFS_IER)   rdata = ier;
            else if (addr < OFS_WIN)    rdata = 8'h00;
            else if (win_hit)           rdata = mode[0] ? acc_sel : rx_byte;
        end
    end
endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
    import canctl_pkg::*;
#(
    parameter int WIN_BYTES = 13,
    parameter int ACC_BYTES = 8,
    localparam int IDX_W = $clog2(WIN_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     host_wr,
    input  logic                     host_rd,
    input  logic [4:0]               host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    output logic                     irq,
    output logic                     ext_map_en,
    output logic                     tx_req,
    output logic [WIN_BYTES*8-1:0]   tx_frame,
    input  logic                     tx_done,
    output logic [ACC_BYTES*8-1:0]   acc_cfg,
    output logic                     op_enter,
    output logic                     rx_release,
    output logic                     ovr_clear,
    input  logic                     rx_pending,
    input  logic                     rx_stored,
    input  logic                     rx_overrun,
    output logic [IDX_W-1:0]         rx_win_idx,
    input  logic [7:0]               rx_win_data
);
    ctrl_t                        c_d, c_q;
    logic [ACC_BYTES-1:0][7:0]    acc_d, acc_q;
    logic [WIN_BYTES-1:0][7:0]    txb_d, txb_q;

    strobe_t                      stb;
    logic                         win_hit;
    logic [IDX_W-1:0]             win_idx;
    logic [7:0]                   status_byte;
    logic [7:0]                   int_byte;

    canctl_decode #(.WIN_BYTES(WIN_BYTES)) u_decode (
        .wr      (host_wr),
        .rd      (host_rd),
        .addr    (host_addr),
        .ext     (c_q.cdr[7]),
        .stb     (stb),
        .win_hit (win_hit),
        .win_idx (win_idx)
    );

    assign status_byte = {2'b00, c_q.tx_stat, c_q.rx_stat, c_q.tx_cplt,
                          c_q.txbuf_free, c_q.ovr, rx_pending};
    assign int_byte    = {4'b0000, c_q.int_ovr, 1'b0, c_q.int_tx, c_q.int_rx};

    canctl_rdmux #(.WIN_BYTES(WIN_BYTES), .ACC_BYTES(ACC_BYTES)) u_rdmux (
        .addr    (host_addr),
        .ext     (c_q.cdr[7]),
        .mode    (c_q.mode),
        .status  (status_byte),
        .intr    (int_byte),
        .ier     (c_q.ier),
        .cdr     (c_q.cdr),
        .acc     (acc_q),
        .win_hit (win_hit),
        .win_idx (win_idx),
        .rx_byte (rx_win_data),
        .rdata   (host_rdata)
    );

    always_comb begin
        c_d   = c_q;
        acc_d = acc_q;
        txb_d = txb_q;

        c_d.tx_req   = 1'b0;
        c_d.rx_rel   = 1'b0;
        c_d.ovr_clr  = 1'b0;
        c_d.op_enter = 1'b0;

        if (stb.wr_cdr) c_d.cdr = host_wdata;
        if (stb.wr_ier) c_d.ier = host_wdata;

        if (stb.wr_mode) begin
            c_d.mode = host_wdata[4:0];
            if (c_q.mode[0] && !host_wdata[0]) c_d.op_enter = 1'b1;
        end

        if (stb.wr_win) begin
            if (win_idx == '0) c_d.tx_stat = 1'b1;
            if (c_q.mode[0]) begin
                for (int k = 0; k < ACC_BYTES; k++) begin
                    if (win_idx == IDX_W'(k)) acc_d[k] = host_wdata;
                end
            end else begin
                for (int k = 0; k < WIN_BYTES; k++) begin
                    if (win_idx == IDX_W'(k)) txb_d[k] = host_wdata;
                end
            end
        end

        // receive flag: re-armed by a read while messages remain
        c_d.int_rx = rx_stored | (rx_pending & (stb.rd_int | c_q.int_rx));
        if (stb.rd_int) begin
            c_d.int_tx  = 1'b0;
            c_d.int_ovr = 1'b0;
        end

        if (stb.wr_cmd) begin
            if (host_wdata[CMD_TX]) begin
                c_d.tx_req     = 1'b1;
                c_d.txbuf_free = 1'b0;
                c_d.tx_cplt    = 1'b0;
            end
            if (host_wdata[CMD_REL]) c_d.rx_rel = 1'b1;
            if (host_wdata[CMD_OVR]) begin
                c_d.ovr_clr = 1'b1;
                c_d.ovr     = 1'b0;
                c_d.int_ovr = 1'b0;
            end
        end

        // events from neighbours take priority over clears
        if (tx_done) begin
            c_d.txbuf_free = 1'b1;
            c_d.tx_cplt    = 1'b1;
            c_d.tx_stat    = 1'b0;
            c_d.int_tx     = 1'b1;
        end
        if (rx_overrun) begin
            c_d.ovr     = 1'b1;
            c_d.int_ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q   <= CTRL_RST;
            acc_q <= '0;
            txb_q <= '0;
        end else begin
            c_q   <= c_d;
            acc_q <= acc_d;
            txb_q <= txb_d;
        end
    end

    assign irq        = |(c_q.ier & int_byte);
    assign ext_map_en = c_q.cdr[7];
    assign tx_req     = c_q.tx_req;
    assign tx_frame   = txb_q;
    assign acc_cfg    = acc_q;
    assign op_enter   = c_q.op_enter;
    assign rx_release = c_q.rx_rel;
    assign ovr_clear  = c_q.ovr_clr;
    assign rx_win_idx = win_idx;
endmodule

// File: rtl/canctl_regs_chk.sv
module canctl_regs_chk
    import canctl_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [CR_AW-1:0] host_addr,
    input logic [7:0]       host_wdata,
    input logic [7:0]       host_rdata,
    input logic             ext,
    input logic             mode0,
    input logic             op_enter,
    input logic             tx_req,
    input logic             tx_done,
    input logic             rx_overrun,
    input logic             rx_pending,
    input logic [7:0]       status,
    input logic             int_rx
);
    assert_tx_pulse_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> $past(host_wr && ext && host_addr == OFS_CMD && host_wdata[CMD_TX]));

    assert_op_enter_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_enter |-> (!mode0 && $past(mode0)));

    assert_status_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && ext && host_addr == OFS_STAT && !tx_done && !rx_overrun)
        |=> (status[7:1] == $past(status[7:1])));

    assert_cmd_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ext && host_addr == OFS_CMD) |-> (host_rdata == 8'h00));

    assert_hidden_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !ext && host_addr != OFS_CDR) |-> (host_rdata == 8'hFF));

    assert_rx_flag_rearm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ext && host_addr == OFS_INT && rx_pending) |=> int_rx);

    assert_mode_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && ext && host_addr == OFS_MODE) |-> (host_rdata[7:5] == 3'b000));
endmodule

bind canctl_regs canctl_regs_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ext        (c_q.cdr[7]),
    .mode0      (c_q.mode[0]),
    .op_enter   (op_enter),
    .tx_req     (tx_req),
    .tx_done    (tx_done),
    .rx_overrun (rx_overrun),
    .rx_pending (rx_pending),
    .status     (status_byte),
    .int_rx     (c_q.int_rx)
);

// File: tb/canctl_regs_tb.sv
`timescale 1ns/1ps
module canctl_regs_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_wr = 1'b0, host_rd = 1'b0;
    logic [4:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic [7:0]   host_rdata;
    logic         irq, ext_map_en, tx_req, op_enter, rx_release, ovr_clear;
    logic [103:0] tx_frame;
    logic [63:0]  acc_cfg;
    logic         tx_done = 1'b0, rx_pending = 1'b0, rx_stored = 1'b0, rx_overrun = 1'b0;
    logic [3:0]   rx_win_idx;
    logic [7:0]   rx_win_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] rv;

    always #2 clk = ~clk;

    assign rx_win_data = {4'hA, rx_win_idx};

    canctl_regs u_dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .ext_map_en(ext_map_en), .tx_req(tx_req), .tx_frame(tx_frame),
        .tx_done(tx_done), .acc_cfg(acc_cfg), .op_enter(op_enter),
        .rx_release(rx_release), .ovr_clear(ovr_clear), .rx_pending(rx_pending),
        .rx_stored(rx_stored), .rx_overrun(rx_overrun), .rx_win_idx(rx_win_idx),
        .rx_win_data(rx_win_data)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(req, {24'h0, d}, {24'h0, exp});
    endtask

    task automatic pulse_tx_done;
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
    endtask

    task automatic t_reset_and_map;
        chk("R1 irq low", {31'h0, irq}, 32'h0);
        chk("R2 map off", {31'h0, ext_map_en}, 32'h0);
        rd_chk("R1 cdr reset", 5'd31, 8'h00);
        rd_chk("R2 hidden mode", 5'd0, 8'hFF);
        wr(5'd4, 8'hFF);                        // must be ignored (R2)
        wr(5'd31, 8'h80);
        chk("R2 map on", {31'h0, ext_map_en}, 32'h1);
        rd_chk("R1 mode reset", 5'd0, 8'h01);
        rd_chk("R1 status reset", 5'd2, 8'h3C);
        rd_chk("R1 int reset", 5'd3, 8'h00);
        rd_chk("R2 ier untouched while hidden", 5'd4, 8'h00);
    endtask

    task automatic t_window_reset;
        for (int k = 0; k < 8; k++) wr(5'(16 + k), 8'(8'h10 + k));
        for (int k = 0; k < 8; k++) rd_chk("R5 acc readback", 5'(16 + k), 8'(8'h10 + k));
        for (int k = 0; k < 8; k++) chk("R5 acc_cfg", {24'h0, acc_cfg[8*k +: 8]}, 32'(8'h10 + k));
        for (int k = 24; k < 29; k++) rd_chk("R5 high window zero", 5'(k), 8'h00);
    endtask

    task automatic t_mode;
        wr(5'd0, 8'hE9);
        chk("R4 no pulse staying in reset", {31'h0, op_enter}, 32'h0);
        rd_chk("R3 mode masked", 5'd0, 8'h09);
        wr(5'd0, 8'h08);
        chk("R4 pulse on leaving reset", {31'h0, op_enter}, 32'h1);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'h0, op_enter}, 32'h0);
        rd_chk("R3 mode readback", 5'd0, 8'h08);
        wr(5'd0, 8'h00);
        chk("R4 no pulse staying operating", {31'h0, op_enter}, 32'h0);
    endtask

    task automatic t_window_op;
        for (int k = 0; k < 13; k++) wr(5'(16 + k), 8'(8'hC0 + k));
        for (int k = 0; k < 13; k++) chk("R6 tx_frame byte", {24'h0, tx_frame[8*k +: 8]}, 32'(8'hC0 + k));
        chk("R6 acc untouched", {24'h0, acc_cfg[7:0]}, 32'h10);
        rd_chk("R6 rx window read", 5'd20, 8'hA4);
        rd_chk("R6 rx window last", 5'd28, 8'hAC);
    endtask

    task automatic t_tx;
        wr(5'd1, 8'h01);
        chk("R8 tx_req pulse", {31'h0, tx_req}, 32'h1);
        rd_chk("R8 status after request", 5'd2, 8'h30);
        chk("R8 tx_req gone", {31'h0, tx_req}, 32'h0);
        pulse_tx_done();
        rd_chk("R8 status after done", 5'd2, 8'h1C);
        rd_chk("R8 tx interrupt", 5'd3, 8'h02);
        rd_chk("R11 read cleared", 5'd3, 8'h00);
        wr(5'd16, 8'h55);
        rd_chk("R7 offset16 sets bit5", 5'd2, 8'h3C);
    endtask

    task automatic t_irq_tx;
        wr(5'd4, 8'h02);
        rd_chk("R12 ier readback", 5'd4, 8'h02);
        chk("R12 irq idle", {31'h0, irq}, 32'h0);
        wr(5'd1, 8'h01);
        pulse_tx_done();
        chk("R12 irq on tx", {31'h0, irq}, 32'h1);
        rd_chk("R12 int value", 5'd3, 8'h02);
        chk("R12 irq after read", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_rx;
        @(negedge clk); rx_pending = 1'b1; rx_stored = 1'b1;
        @(negedge clk); rx_stored = 1'b0;
        rd_chk("R11 status pending", 5'd2, 8'h1D);
        wr(5'd4, 8'h01);
        chk("R12 irq on rx", {31'h0, irq}, 32'h1);
        rd_chk("R11 rx flag", 5'd3, 8'h01);
        rd_chk("R11 rx flag rearmed", 5'd3, 8'h01);
        wr(5'd1, 8'h04);
        chk("R9 release pulse", {31'h0, rx_release}, 32'h1);
        chk("R9 no tx on release", {31'h0, tx_req}, 32'h0);
        @(negedge clk); rx_pending = 1'b0;
        @(negedge clk);
        chk("R12 irq drops with pending", {31'h0, irq}, 32'h0);
        rd_chk("R11 int empty", 5'd3, 8'h00);
        rd_chk("R11 status empty", 5'd2, 8'h1C);
    endtask

    task automatic t_overrun;
        wr(5'd4, 8'h08);
        @(negedge clk); rx_overrun = 1'b1;
        @(negedge clk); rx_overrun = 1'b0;
        chk("R12 irq on overrun", {31'h0, irq}, 32'h1);
        rd_chk("R9 overrun status", 5'd2, 8'h1E);
        wr(5'd1, 8'h08);
        chk("R9 clear pulse", {31'h0, ovr_clear}, 32'h1);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        rd_chk("R9 overrun cleared", 5'd2, 8'h1C);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 5'd1; host_wdata = 8'h08; rx_overrun = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; rx_overrun = 1'b0;
        rd_chk("R9 set wins over clear", 5'd2, 8'h1E);
        wr(5'd1, 8'h08);
        rd_chk("R9 cleared again", 5'd2, 8'h1C);
    endtask

    task automatic t_misc;
        rd_chk("R10 cmd reads zero", 5'd1, 8'h00);
        rd_chk("R10 reserved zero", 5'd9, 8'h00);
        rd_chk("R10 reserved 15", 5'd15, 8'h00);
        rd_chk("R10 unmapped", 5'd29, 8'hFF);
        wr(5'd2, 8'h00);
        rd_chk("R10 status write ignored", 5'd2, 8'h1C);
        wr(5'd3, 8'hFF);
        chk("R10 int write no irq", {31'h0, irq}, 32'h0);
        rd_chk("R10 int write ignored", 5'd3, 8'h00);
    endtask

    task automatic t_map_off;
        wr(5'd31, 8'h00);
        chk("R2 map off again", {31'h0, ext_map_en}, 32'h0);
        rd_chk("R2 hidden status", 5'd2, 8'hFF);
        wr(5'd4, 8'hFF);
        rd_chk("R2 cdr readable", 5'd31, 8'h00);
        wr(5'd31, 8'h80);
        rd_chk("R2 ier kept", 5'd4, 8'h08);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_and_map();
        t_window_reset();
        t_mode();
        t_window_op();
        t_tx();
        t_irq_tx();
        t_rx();
        t_overrun();
        t_misc();
        t_map_off();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule